// File: doc/BRIEF.md
# Clock Output Gate with Synchronized Power-Down

This block sits between the clock generators of a system clock chip and its output pads. For every clock output it decides whether the output follows its source clock or is held low. Every clock group has its own source clock: processor, memory, peripheral bus, interrupt-controller, 48 MHz, super-I/O and memory-feedback. The block does not generate or divide any clock.

Three controls act on the outputs. An asynchronous active-low power-down request is synchronized to the processor clock. It is accepted only after two consecutive low samples, and it then parks every output low. Per-output enable bits park individual outputs low. A test-mode bit withdraws the pad drive enable so the pads three-state.

Enables are registered on the falling edge of each output's own clock and ANDed with that clock. As a result, an output is stopped only after a complete high phase and restarted only at a rising edge. No runt pulse appears in either direction.

Top module: `clkgate_top`

## Requirements
- R1: While `rst_ni` is low, every clock output is low, including during the source clock's high phase.
- R2: Power-down is accepted only when `pd_ni` is sampled low on two consecutive rising edges of `clk_cpu_i`. A low seen on only one rising edge has no effect on any output.
- R3: Take two consecutive rising edges k and k+1 at which `pd_ni` is sampled low. Every output, including the processor outputs, still delivers its full high phase after edge k+2. Every output is low from edge k+3 onward.
- R4: An output that is enabled and not powered down is high during its source clock's high phase and low during its low phase.
- R5: An output whose enable bit is 0 is held low. An enable change made during a high phase takes effect at the next falling edge, so the high phase already in progress is not shortened.
- R6: Enable bit i of `en_sdram_i` gates `sdram_o[i]`, and bit i of `en_pci_i` gates `pci_o[i]`. `en_usb_i` gates both `usb_o` outputs. `en_sio_i`, `en_apic_i` and `en_dclk_i` each gate their single output. The processor outputs have no enable bit.
- R7: Power-down is released only when `pd_ni` is sampled high on two consecutive rising edges k and k+1. Outputs stay low through the high phase after edge k+2 and are first high after edge k+3.
- R8: `drive_en_o` is 0 while `test_mode_i` is 1, so that the pads three-state, and is 1 otherwise. Test mode does not change the clock values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous active-low reset |
| pd_ni | input | 1 | Asynchronous active-low power-down request |
| test_mode_i | input | 1 | 1 withdraws the pad drive enable |
| en_sdram_i | input | 8 | Per-output memory clock enables |
| en_pci_i | input | 8 | Per-output peripheral bus clock enables |
| en_apic_i | input | 1 | Interrupt-controller clock enable |
| en_dclk_i | input | 1 | Memory-feedback clock enable |
| en_usb_i | input | 1 | Enable for both 48 MHz outputs |
| en_sio_i | input | 1 | Super-I/O clock enable |
| clk_cpu_i | input | 1 | Processor source clock; also the power-down sampling clock |
| clk_sdram_i | input | 1 | Memory source clock |
| clk_pci_i | input | 1 | Peripheral bus source clock |
| clk_apic_i | input | 1 | Interrupt-controller source clock |
| clk_usb_i | input | 1 | 48 MHz source clock |
| clk_sio_i | input | 1 | Super-I/O source clock |
| clk_dclk_i | input | 1 | Memory-feedback source clock |
| cpu_o | output | 2 | Gated processor clocks |
| sdram_o | output | 8 | Gated memory clocks |
| pci_o | output | 8 | Gated peripheral bus clocks |
| apic_o | output | 1 | Gated interrupt-controller clock |
| dclk_o | output | 1 | Gated memory-feedback clock |
| usb_o | output | 2 | Gated 48 MHz clocks |
| sio_o | output | 1 | Gated super-I/O clock |
| drive_en_o | output | 1 | Pad drive enable, 0 in test mode |

## Verification
The enable inputs are driven with several patterns: all set, all clear, and alternating and complementary patterns across the memory and peripheral groups. These patterns separate a wrong bit-to-output mapping from a stuck or shared enable, and show that the processor outputs ignore every enable. The power-down input is driven in three ways. A low seen at only one sampling edge separates two-sample acceptance from single-sample acceptance. A held low checks the exact edge at which the outputs stop. A held high checks the exact edge at which they resume. An enable cleared in the middle of a high phase separates falling-edge gating from plain combinational gating, which would cut that pulse short.

// File: rtl/clkgate_pkg.sv
`timescale 1ns/1ps
package clkgate_pkg;
    localparam int N_CPU_DEF   = 2;
    localparam int N_SDRAM_DEF = 8;
    localparam int N_PCI_DEF   = 8;
    localparam int N_USB_DEF   = 2;

    // power-down synchronizer state: two consecutive samples plus accepted flag
    typedef struct packed {
        logic smp_new;
        logic smp_old;
        logic halted;
    } pd_state_t;
endpackage

// File: rtl/clkgate_pd_sync.sv
`timescale 1ns/1ps
module clkgate_pd_sync
    import clkgate_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pd_ni,
    output logic halt_o
);
    pd_state_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.smp_new = ~pd_ni;
        st_d.smp_old = st_q.smp_new;
        if (st_q.smp_new && st_q.smp_old) begin
            st_d.halted = 1'b1;
        end else if (!st_q.smp_new && !st_q.smp_old) begin
            st_d.halted = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign halt_o = st_q.halted;

    // R2: acceptance needs two consecutive low samples of the request
    p_two_low_samples_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(halt_o) |-> (!$past(pd_ni, 2) && !$past(pd_ni, 3)));

    // R7: release needs two consecutive high samples of the request
    p_two_high_samples_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(halt_o) |-> ($past(pd_ni, 2) && $past(pd_ni, 3)));
endmodule

// File: rtl/clkgate_bank.sv
`timescale 1ns/1ps
module clkgate_bank #(
    parameter int N = 1
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] en_i,
    output logic [N-1:0] gclk_o
);
    typedef struct packed {
        logic [N-1:0] en;
    } bank_state_t;

    bank_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.en = en_i;
    end

    // enables change only while the source clock is low
    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_gate
        assign gclk_o[g] = clk_i & st_q.en[g];
    end

    logic armed_q;
    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            armed_q <= 1'b0;
        end else begin
            armed_q <= 1'b1;
        end
    end

    // R5: an enable seen low at a falling edge keeps the next high phase low
    p_disabled_stays_low_r5: assert property (@(negedge clk_i) disable iff (!rst_ni)
        armed_q |-> ((gclk_o & ~$past(en_i)) == '0));

    // R4: an enable seen high at a falling edge passes the whole next high phase
    p_enabled_passes_r4: assert property (@(negedge clk_i) disable iff (!rst_ni)
        armed_q |-> ((~gclk_o & $past(en_i)) == '0));
endmodule

// File: rtl/clkgate_top.sv
`timescale 1ns/1ps
module clkgate_top
    import clkgate_pkg::*;
#(
    parameter int N_CPU   = N_CPU_DEF,
    parameter int N_SDRAM = N_SDRAM_DEF,
    parameter int N_PCI   = N_PCI_DEF,
    parameter int N_USB   = N_USB_DEF
) (
    input  logic               rst_ni,
    input  logic               pd_ni,
    input  logic               test_mode_i,
    input  logic [N_SDRAM-1:0] en_sdram_i,
    input  logic [N_PCI-1:0]   en_pci_i,
    input  logic               en_apic_i,
    input  logic               en_dclk_i,
    input  logic               en_usb_i,
    input  logic               en_sio_i,
    input  logic               clk_cpu_i,
    input  logic               clk_sdram_i,
    input  logic               clk_pci_i,
    input  logic               clk_apic_i,
    input  logic               clk_usb_i,
    input  logic               clk_sio_i,
    input  logic               clk_dclk_i,
    output logic [N_CPU-1:0]   cpu_o,
    output logic [N_SDRAM-1:0] sdram_o,
    output logic [N_PCI-1:0]   pci_o,
    output logic               apic_o,
    output logic               dclk_o,
    output logic [N_USB-1:0]   usb_o,
    output logic               sio_o,
    output logic               drive_en_o
);
    typedef struct packed {
        logic [N_CPU-1:0]   cpu;
        logic [N_SDRAM-1:0] sdram;
        logic [N_PCI-1:0]   pci;
        logic               apic;
        logic               dclk;
        logic [N_USB-1:0]   usb;
        logic               sio;
    } gate_en_t;

    logic     halt;
    gate_en_t gate_d;

    clkgate_pd_sync u_pd_sync (
        .clk_i  (clk_cpu_i),
        .rst_ni (rst_ni),
        .pd_ni  (pd_ni),
        .halt_o (halt)
    );

    always_comb begin
        gate_d.cpu   = {N_CPU{~halt}};
        gate_d.sdram = en_sdram_i & {N_SDRAM{~halt}};
        gate_d.pci   = en_pci_i & {N_PCI{~halt}};
        gate_d.apic  = en_apic_i & ~halt;
        gate_d.dclk  = en_dclk_i & ~halt;
        gate_d.usb   = {N_USB{en_usb_i & ~halt}};
        gate_d.sio   = en_sio_i & ~halt;
    end

    clkgate_bank #(.N(N_CPU)) u_cpu (
        .clk_i(clk_cpu_i), .rst_ni(rst_ni), .en_i(gate_d.cpu), .gclk_o(cpu_o));
    clkgate_bank #(.N(N_SDRAM)) u_sdram (
        .clk_i(clk_sdram_i), .rst_ni(rst_ni), .en_i(gate_d.sdram), .gclk_o(sdram_o));
    clkgate_bank #(.N(N_PCI)) u_pci (
        .clk_i(clk_pci_i), .rst_ni(rst_ni), .en_i(gate_d.pci), .gclk_o(pci_o));
    clkgate_bank #(.N(1)) u_apic (
        .clk_i(clk_apic_i), .rst_ni(rst_ni), .en_i(gate_d.apic), .gclk_o(apic_o));
    clkgate_bank #(.N(1)) u_dclk (
        .clk_i(clk_dclk_i), .rst_ni(rst_ni), .en_i(gate_d.dclk), .gclk_o(dclk_o));
    clkgate_bank #(.N(N_USB)) u_usb (
        .clk_i(clk_usb_i), .rst_ni(rst_ni), .en_i(gate_d.usb), .gclk_o(usb_o));
    clkgate_bank #(.N(1)) u_sio (
        .clk_i(clk_sio_i), .rst_ni(rst_ni), .en_i(gate_d.sio), .gclk_o(sio_o));

    // R8: pads three-state in test mode
    assign drive_en_o = ~test_mode_i;
endmodule

// File: tb/clkgate_top_test.sv
`timescale 1ns/1ps
module clkgate_top_test;
    localparam int W = 23;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n, pd_n, test_mode;
    logic [7:0] en_sdram, en_pci;
    logic       en_apic, en_dclk, en_usb, en_sio;
    logic [1:0] cpu_o, usb_o;
    logic [7:0] sdram_o, pci_o;
    logic       apic_o, dclk_o, sio_o, drive_en_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    clkgate_top uut (
        .rst_ni(rst_n), .pd_ni(pd_n), .test_mode_i(test_mode),
        .en_sdram_i(en_sdram), .en_pci_i(en_pci), .en_apic_i(en_apic),
        .en_dclk_i(en_dclk), .en_usb_i(en_usb), .en_sio_i(en_sio),
        .clk_cpu_i(clk), .clk_sdram_i(clk), .clk_pci_i(clk), .clk_apic_i(clk),
        .clk_usb_i(clk), .clk_sio_i(clk), .clk_dclk_i(clk),
        .cpu_o(cpu_o), .sdram_o(sdram_o), .pci_o(pci_o), .apic_o(apic_o),
        .dclk_o(dclk_o), .usb_o(usb_o), .sio_o(sio_o), .drive_en_o(drive_en_o)
    );

    typedef struct packed {
        logic [7:0] sdram;
        logic [7:0] pci;
        logic       apic;
        logic       dclk;
        logic       usb;
        logic       sio;
        logic       test;
        logic       exp_drive;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{8'hFF, 8'hFF, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
        '{8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        '{8'hA5, 8'h3C, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
        '{8'h5A, 8'hC3, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
        '{8'h01, 8'h80, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
        '{8'hFE, 8'h7F, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0}
    };

    function automatic logic [W-1:0] snap();
        return {cpu_o, sdram_o, pci_o, apic_o, dclk_o, usb_o, sio_o};
    endfunction

    // expected high-phase output vector from R6 mapping
    function automatic logic [W-1:0] expect_high(bit run);
        if (!run) return '0;
        return {2'b11, en_sdram, en_pci, en_apic, en_dclk, {2{en_usb}}, en_sio};
    endfunction

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic at_high();
        @(posedge clk);
        #1;
    endtask

    task automatic all_on();
        en_sdram = 8'hFF; en_pci = 8'hFF;
        en_apic = 1'b1; en_dclk = 1'b1; en_usb = 1'b1; en_sio = 1'b1;
        test_mode = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; pd_n = 1'b1;
        all_on();
        at_high();
        at_high();
        check("R1 outputs low in reset", snap(), '0);
        check("R8 drive enable in reset", W'(drive_en_o), W'(1));
        @(negedge clk); #1;
        rst_n = 1'b1;
        at_high(); at_high(); at_high();
        check("R4 running after reset", snap(), expect_high(1'b1));

        // table walk: R6 mapping and R8 drive enable
        for (int i = 0; i < NV; i++) begin
            en_sdram = VECS[i].sdram; en_pci = VECS[i].pci;
            en_apic = VECS[i].apic; en_dclk = VECS[i].dclk;
            en_usb = VECS[i].usb; en_sio = VECS[i].sio;
            test_mode = VECS[i].test;
            at_high();
            check("R6 enable mapping", snap(), expect_high(1'b1));
            check("R8 drive enable", W'(drive_en_o), W'(VECS[i].exp_drive));
        end
        all_on();
        at_high();

        // R4: low phase is low on every enabled output
        @(negedge clk); #1;
        check("R4 low phase", snap(), '0);

        // R5: disabling mid-high does not shorten the pulse
        at_high();
        en_sdram = 8'hFE;
        #0.5;
        check("R5 pulse in progress kept", W'(sdram_o[0]), W'(1));
        at_high();
        check("R5 disabled output held low", snap(), expect_high(1'b1));
        all_on();
        at_high();

        // R2: a single low sample is ignored
        pd_n = 1'b0;
        at_high();
        pd_n = 1'b1;
        for (int k = 0; k < 4; k++) begin
            at_high();
            check("R2 single low sample ignored", snap(), expect_high(1'b1));
        end

        // R2/R3: two low samples stop outputs after a full high phase
        pd_n = 1'b0;
        at_high();
        check("R3 running after first low sample", snap(), expect_high(1'b1));
        at_high();
        check("R3 running after second low sample", snap(), expect_high(1'b1));
        at_high();
        check("R3 last high phase completes", snap(), expect_high(1'b1));
        at_high();
        check("R2 outputs stopped", snap(), '0);
        at_high();
        check("R3 outputs stay low", snap(), '0);

        // R7: release resumes at a rising edge
        pd_n = 1'b1;
        at_high();
        check("R7 low after first high sample", snap(), '0);
        at_high();
        check("R7 low after second high sample", snap(), '0);
        at_high();
        check("R7 low during release edge phase", snap(), '0);
        at_high();
        check("R7 resumed", snap(), expect_high(1'b1));

        // R8: test mode withdraws drive but clocks keep running
        test_mode = 1'b1;
        #0.5;
        check("R8 drive withdrawn", W'(drive_en_o), W'(0));
        at_high();
        check("R8 clocks unaffected", snap(), expect_high(1'b1));
        test_mode = 1'b0;
        #0.5;
        check("R8 drive restored", W'(drive_en_o), W'(1));

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule